// File: doc/BRIEF.md
# I2C Bus Clear Sequencer

This block frees an I2C bus that a slave is holding down. When a slave stops in the middle of a byte, it can keep SDA low for good. The sequencer then toggles SCL through open-drain enables until the slave lets go of SDA. It can optionally finish with a proper stop condition, and it reports whether SDA ended up high. A clock-enable tick from outside sets the pulse rate, with one SCL phase per tick. Normal transfer logic is not part of this block.

Software writes the pulse threshold and the option bits into a staging register. Those settings only take effect after a write to the load register, and the load bit reads back as 1 until the copy has happened. Setting the go bit in the configuration register starts a run, using the settings that are active at that moment. The go bit reads as 1 for as long as the run lasts. At the end the block raises a one-cycle done pulse and updates the result bit.

Top module: `bus_unstick`

## Requirements
- R1: After reset, scl_oe, sda_oe and done_irq are 0. Address 0 reads 0x00120000, which is a threshold of 18 with all option bits and go at 0. Addresses 1 and 2 read 0.
- R2: Each pulse holds SCL low (scl_oe=1) for one tick and then releases it for one tick. SDA is sampled on the tick that ends the released phase.
- R3: When terminate-on-release is off, a run sends exactly the threshold number of pulses. A threshold of 0 acts as 1.
- R4: When terminate-on-release is on (address 0 bit 1), pulsing stops after the first pulse whose SDA sample is high, and never exceeds the threshold.
- R5: When the stop option is on (address 0 bit 2), the pulses are followed by these steps in order: SCL held low, SDA pulled low, SCL released, SDA released, with one tick for each step. SDA is pulled low only while SCL is already low, and is released only while SCL is released.
- R6: Address 1 bit 0 holds the result of the last run. It is 1 when the final SDA sample was high. That sample is the last pulse sample without the stop option, and the sample taken after SDA is released with it.
- R7: Writing address 0 with bit 0 set starts a run if none is active. Bit 0 of address 0 reads 1 during a run and 0 after it. A go write during a run does not start a second run or change the current one.
- R8: done_irq is high for exactly one cycle per run, in the same cycle in which the run ends.
- R9: The threshold (address 0 bits 23:16) and the option bits are staged. Writing 1 to address 2 bit 0 sets a pending flag, which reads back in that bit. The staged values are copied into the active settings, and the flag cleared, on the first edge on which no run is active. While a run is active, the copy is deferred.
- R10: When a pending copy and a go write fall on the same edge, the copy happens first and the new run uses the freshly copied settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Pulse-rate clock enable, one SCL phase per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 config, 1 status, 2 load |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data, valid the cycle after rd_addr |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| done_irq | output | 1 | One-cycle pulse at the end of a run |

## Verification
A configuration load and a run start can land on the same clock edge. The bench provokes this with a load write directly followed, in the next cycle, by a go write that carries a different threshold from the one currently active. The count of SCL pulses observed on the pins then shows which settings the run used, and R10 requires the new ones. Two further cases are also driven and judged by their pulse counts: a load that arrives during a run, and a go write that arrives during a run.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;
  // register addresses
  localparam int REG_CFG  = 0;
  localparam int REG_STAT = 1;
  localparam int REG_LOAD = 2;
  // field positions in the configuration word
  localparam int CFG_GO_BIT   = 0;
  localparam int CFG_TERM_BIT = 1;
  localparam int CFG_STOP_BIT = 2;
  localparam int CFG_THR_LSB  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_STP_SCL,
    ST_STP_SDA,
    ST_STP_RSCL,
    ST_STP_RSDA
  } seq_st_e;
endpackage

// File: rtl/bus_unstick_regs.sv
module bus_unstick_regs
  import bus_unstick_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2,
  parameter int THR_W   = 8,
  parameter int THR_RST = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              busy,
  input  logic              ok,
  output logic              start,
  output logic [THR_W-1:0]  act_thr,
  output logic              act_term,
  output logic              act_stp
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(REG_CFG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(REG_LOAD);
  localparam logic [THR_W-1:0]  THR_INIT = THR_W'(THR_RST);

  logic [THR_W-1:0]  stg_thr;
  logic              stg_term, stg_stp, pend;
  logic              cfg_wr, load_wr, copy;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wr;

  assign unused_wr = ^wr_data;
  assign cfg_wr  = wr_en && (wr_addr == A_CFG);
  assign load_wr = wr_en && (wr_addr == A_LOAD) && wr_data[0];
  assign copy    = pend && !busy;
  assign start   = cfg_wr && wr_data[CFG_GO_BIT] && !busy;

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_CFG: begin
        rd_mux[CFG_THR_LSB +: THR_W] = stg_thr;
        rd_mux[CFG_STOP_BIT]         = stg_stp;
        rd_mux[CFG_TERM_BIT]         = stg_term;
        rd_mux[CFG_GO_BIT]           = busy;
      end
      A_STAT:  rd_mux[0] = ok;
      A_LOAD:  rd_mux[0] = pend;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_thr  <= THR_INIT;
      stg_term <= 1'b0;
      stg_stp  <= 1'b0;
      act_thr  <= THR_INIT;
      act_term <= 1'b0;
      act_stp  <= 1'b0;
      pend     <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (cfg_wr) begin
        stg_thr  <= wr_data[CFG_THR_LSB +: THR_W];
        stg_term <= wr_data[CFG_TERM_BIT];
        stg_stp  <= wr_data[CFG_STOP_BIT];
      end
      if (load_wr)   pend <= 1'b1;
      else if (copy) pend <= 1'b0;
      if (copy) begin
        act_thr  <= stg_thr;
        act_term <= stg_term;
        act_stp  <= stg_stp;
      end
      rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/bus_unstick_seq.sv
module bus_unstick_seq
  import bus_unstick_pkg::*;
#(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [THR_W-1:0] thr,
  input  logic             term,
  input  logic             stp,
  input  logic             sda_in,
  output logic             busy,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             done,
  output logic             ok
);
  seq_st_e          st_q, st_n;
  logic [THR_W-1:0] cnt_q, cnt_n, thr_eff;
  logic [THR_W:0]   cnt_inc;
  logic             fin, fin_ok;

  assign thr_eff = (thr == '0) ? THR_W'(1) : thr;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    fin    = 1'b0;
    fin_ok = ok;
    case (st_q)
      ST_IDLE: if (start) begin
        st_n  = ST_LOW;
        cnt_n = '0;
      end
      ST_LOW: if (tick) st_n = ST_HIGH;
      ST_HIGH: if (tick) begin
        cnt_n = cnt_inc[THR_W-1:0];
        if ((term && sda_in) || (cnt_inc >= {1'b0, thr_eff})) begin
          if (stp) st_n = ST_STP_SCL;
          else begin
            st_n   = ST_IDLE;
            fin    = 1'b1;
            fin_ok = sda_in;
          end
        end else begin
          st_n = ST_LOW;
        end
      end
      ST_STP_SCL:  if (tick) st_n = ST_STP_SDA;
      ST_STP_SDA:  if (tick) st_n = ST_STP_RSCL;
      ST_STP_RSCL: if (tick) st_n = ST_STP_RSDA;
      ST_STP_RSDA: if (tick) begin
        st_n   = ST_IDLE;
        fin    = 1'b1;
        fin_ok = sda_in;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      busy   <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
      ok     <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      busy   <= (st_n != ST_IDLE);
      scl_oe <= (st_n == ST_LOW) || (st_n == ST_STP_SCL) || (st_n == ST_STP_SDA);
      sda_oe <= (st_n == ST_STP_SDA) || (st_n == ST_STP_RSCL);
      done   <= fin;
      ok     <= fin_ok;
    end
  end
endmodule

// File: rtl/bus_unstick.sv
module bus_unstick #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2,
  parameter int THR_W   = 8,
  parameter int THR_RST = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              done_irq
);
  logic             seq_busy, seq_ok, start;
  logic [THR_W-1:0] act_thr;
  logic             act_term, act_stp;

  bus_unstick_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .THR_W(THR_W), .THR_RST(THR_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(seq_busy), .ok(seq_ok),
    .start(start), .act_thr(act_thr), .act_term(act_term), .act_stp(act_stp)
  );

  bus_unstick_seq #(.THR_W(THR_W)) u_seq (
    .clk(clk), .rst(rst), .tick(tick_en), .start(start), .thr(act_thr),
    .term(act_term), .stp(act_stp), .sda_in(sda_in), .busy(seq_busy),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done_irq), .ok(seq_ok)
  );
endmodule

// File: rtl/bus_unstick_chk.sv
module bus_unstick_chk #(
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             done_irq,
  input logic             busy,
  input logic [THR_W-1:0] act_thr,
  input logic             act_term,
  input logic             act_stp
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe)); // R7
  AST_SDA_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> (scl_oe && $past(scl_oe))); // R5
  AST_SDA_FREE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> (!scl_oe && !$past(scl_oe))); // R5
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_irq); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> !busy); // R8
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable({act_thr, act_term, act_stp})); // R9
endmodule

bind bus_unstick bus_unstick_chk #(.THR_W(THR_W)) u_chk (
  .clk(clk), .rst(rst), .scl_oe(scl_oe), .sda_oe(sda_oe), .done_irq(done_irq),
  .busy(seq_busy), .act_thr(act_thr), .act_term(act_term), .act_stp(act_stp)
);

// File: tb/bus_unstick_tb_top.sv
module bus_unstick_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic sda_in;
  logic scl_oe, sda_oe, done_irq;

  int n_chk = 0, n_bad = 0;
  int scl_lows = 0, scl_rels = 0, sda_lows = 0, dones = 0;
  int rel_base = 0, k_rel = 0;
  logic scl_p = 1'b0, sda_p = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // slave model: lets SDA go once it has seen k_rel SCL releases
  assign sda_in = !sda_oe && ((scl_rels - rel_base) >= k_rel);

  bus_unstick dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done_irq(done_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tick_en <= lfsr[0] | lfsr[3];
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (scl_oe && !scl_p) scl_lows++;
      if (!scl_oe && scl_p) scl_rels++;
      if (sda_oe && !sda_p) sda_lows++;
      if (done_irq) dones++;
    end
    scl_p = scl_oe;
    sda_p = sda_oe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    rd_addr = ADDR_W'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic logic [31:0] cfgw(input int thr, input int term, input int stp, input int go);
    return (32'(thr & 255) << 16) | (32'(stp & 1) << 2) | (32'(term & 1) << 1) | 32'(go & 1);
  endfunction

  function automatic int exp_p(input int thr, input int term, input int k);
    int te = (thr == 0) ? 1 : thr;
    if (!term) return te;
    if (k <= 1) return 1;
    return (k < te) ? k : te;
  endfunction

  function automatic int exp_ok(input int p, input int stp, input int k);
    return stp ? int'(p + 1 >= k) : int'(p >= k);
  endfunction

  task automatic load(input int thr, input int term, input int stp);
    logic [31:0] v;
    wr(0, cfgw(thr, term, stp, 0));
    wr(2, 32'd1);
    v = 32'd1;
    for (int i = 0; i < 20; i++) begin
      rd(2, v);
      if (v[0] == 1'b0) break;
    end
    chk("R9 load bit clears when idle", int'(v[0]), 0);
  endtask

  task automatic go_run(input int athr, input int aterm, input int astp, input int k,
                        input logic [31:0] goword, input int meddle, input string tag);
    int b_low, b_sda, b_done, p, seen;
    logic [31:0] v;
    b_low = scl_lows; b_sda = sda_lows; b_done = dones;
    rel_base = scl_rels; k_rel = k;
    wr(0, goword | 32'd1);
    if (meddle != 0) begin
      repeat (3) @(negedge clk);
      wr(0, cfgw(4, 0, 0, 1));   // go while running must be ignored (R7)
      wr(2, 32'd1);
      rd(2, v);
      chk("R9 load held pending during run", int'(v[0]), 1);
      rd(0, v);
      chk("R7 go bit reads 1 while running", int'(v[0]), 1);
    end
    seen = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done_irq) begin seen = 1; break; end
      @(negedge clk);
    end
    chk({tag, " R8 run finished"}, seen, 1);
    repeat (2) @(negedge clk);
    p = exp_p(athr, aterm, k);
    chk({tag, " R2 SCL low phases"}, scl_lows - b_low, p + astp);
    chk({tag, " R5 SDA pulls"}, sda_lows - b_sda, astp);
    chk({tag, " R8 one done pulse"}, dones - b_done, 1);
    rd(0, v);
    chk({tag, " R7 go bit cleared"}, int'(v[0]), 0);
    rd(1, v);
    chk({tag, " R6 result bit"}, int'(v[0]), exp_ok(p, astp, k));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned dummy;
    dummy = $urandom(32'd1357);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 done_irq", int'(done_irq), 0);
    rd(0, v); chk("R1 config word", int'(v), 32'h0012_0000);
    rd(1, v); chk("R1 status", int'(v), 0);
    rd(2, v); chk("R1 load", int'(v), 0);

    // R3 default threshold without any load, slave already free
    go_run(18, 0, 0, 0, cfgw(18, 0, 0, 1), 0, "R3 default 18");
    load(0, 0, 0);
    go_run(0, 0, 0, 0, cfgw(0, 0, 0, 1), 0, "R3 zero threshold");
    load(5, 0, 0);
    go_run(5, 0, 0, 100, cfgw(5, 0, 0, 1), 0, "R6 stays stuck");
    load(20, 1, 0);
    go_run(20, 1, 0, 7, cfgw(20, 1, 0, 1), 0, "R4 early release");
    load(6, 0, 1);
    go_run(6, 0, 1, 100, cfgw(6, 0, 1, 1), 0, "R5 stop stuck");
    go_run(6, 0, 1, 7, cfgw(6, 0, 1, 1), 0, "R5 stop frees");

    // R9 deferred load, R7 go during run ignored
    load(10, 0, 0);
    go_run(10, 0, 0, 100, cfgw(10, 0, 0, 1), 1, "R9 deferred");
    rd(2, v); chk("R9 deferred copy done after run", int'(v[0]), 0);
    go_run(4, 0, 0, 100, cfgw(4, 0, 0, 1), 0, "R9 applied after run");
    go_run(4, 0, 0, 100, cfgw(7, 0, 0, 1), 0, "R9 staged only");

    // R10 load pending and go on the same edge
    wr(0, cfgw(6, 1, 0, 0));
    wr(2, 32'd1);
    go_run(6, 1, 0, 3, cfgw(6, 1, 0, 1), 0, "R10 same edge");

    // random mix
    for (int n = 0; n < 14; n++) begin
      int thr = int'($urandom % 41);
      int term = int'($urandom % 2);
      int stp = int'($urandom % 2);
      int k = int'($urandom % 45);
      load(thr, term, stp);
      go_run(thr, term, stp, k, cfgw(thr, term, stp, 1), 0, "R4 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule